// File: doc/BRIEF.md
# SPI Slave Register Access Frame

This block is a SPI slave that lets an external master read and write a small internal register file. Every transaction is one framed exchange under an active-low chip select. The master first sends the target address as two bytes, high byte first. Next it sends a control byte that sets the direction. Then it sends one or more data bytes. Transfers use SPI mode 0 with the most significant bit first.

The slave shifts out a byte on MISO in the same byte period as each MOSI byte. While the three header bytes arrive, MISO returns a fixed signature, so the master always sees defined data there. In the data phase MISO carries register contents for a read and zero for a write. If the frame runs past the first data byte, the address advances after each data byte, which gives burst access.

The serial pins are sampled in the system clock domain through synchronizers. The system clock must therefore run several times faster than SCLK: at least eight system clocks per SCLK half period.

Top module: `spi_regacc`

## Requirements
- R1: A frame carries the address high byte, the address low byte, a control byte and then data bytes, in that order. A single register access takes exactly four bytes.
- R2: During the three header bytes MISO returns 0x01, then 0x02, then 0x03, one value per header byte. Each value goes out in the same byte period as the matching MOSI byte.
- R3: Bits move most significant first in SPI mode 0. SCLK idles low, both sides sample on the rising edge, and MISO changes after the falling edge. The first MISO bit of a frame is valid before the first rising edge.
- R4: Bit 2 of the control byte sets the direction: 1 means write and 0 means read. The other control bits have no effect. MOSI data sent during a read frame does not change any register.
- R5: In a read frame, each data-phase MISO byte is the content of the addressed register. The register index is the address modulo the register count, which is the low 4 bits for the default 16 registers.
- R6: In a write frame, MISO is 0x00 for every data-phase byte, and each complete data byte is stored at the addressed register.
- R7: After each data byte the 16-bit address increments by one. A burst therefore moves to consecutive registers and wraps from the last register back to register 0.
- R8: Raising chip select at any point clears the bit and byte counters, and a data byte with fewer than 8 bits received is not stored. The next frame starts again with the header signature.
- R9: MISO is driven low while chip select is high.
- R10: A synchronous active-low reset clears every register to zero and returns the frame logic to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low chip select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
The assertions check the following on every cycle. The bit counter and MISO go to zero one cycle after deselect. A completed byte only comes from a full eight-bit count. The header byte counter advances by one per byte. The address steps by exactly one after each data byte. Reset clears the whole register file. The scenarios show what no single-cycle property can: the signature bytes as the master sees them in MSB-first order, read data matching earlier writes at every register through aliased addresses, a burst wrapping past the last register, and aborted frames leaving registers unchanged.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // Header signature: byte position 0 returns 1, position 1 returns 2, ...
   function automatic byte_t sig_byte(input int unsigned pos);
      return byte_t'(pos + 1);
   endfunction
endpackage

// File: rtl/spi_regacc_sync.sv
module spi_regacc_sync #(
   parameter int unsigned WIDTH     = 3,
   parameter int unsigned STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_regacc_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) pipe[i] <= RESET_VAL;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_regacc_shifter.sv
module spi_regacc_shifter
   import spi_regacc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sclk_s,
   input  logic  csn_s,
   input  logic  mosi_s,
   input  byte_t next_tx,
   output logic  sel,
   output logic  byte_done,
   output byte_t rx_byte,
   output logic  miso
);
   localparam int unsigned BIT_W = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   logic             sclk_q;
   logic             csn_q;
   logic [BIT_W-1:0] bit_cnt;
   byte_t            rx_sh;
   byte_t            tx_sh;
   logic             rise;
   logic             fall;
   logic             frame_start;

   assign sel         = !csn_s;
   assign rise        = sel && sclk_s && !sclk_q;
   assign fall        = sel && !sclk_s && sclk_q;
   assign frame_start = csn_q && !csn_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         csn_q     <= 1'b1;
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else begin
         sclk_q    <= sclk_s;
         csn_q     <= csn_s;
         byte_done <= 1'b0;
         if (!sel) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
         end else if (frame_start) begin
            bit_cnt <= '0;
            tx_sh   <= next_tx;
         end else begin
            if (rise) begin
               rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == LAST_BIT) begin
                  byte_done <= 1'b1;
                  rx_byte   <= {rx_sh[BYTE_W-2:0], mosi_s};
               end
            end
            if (fall) begin
               if (bit_cnt == '0) tx_sh <= next_tx;
               else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso = tx_sh[BYTE_W-1];

   p_bitcnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (bit_cnt == '0));
   p_miso_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !miso);
   p_full_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> ($past(bit_cnt) == LAST_BIT));
endmodule

// File: rtl/spi_regacc_ctrl.sv
module spi_regacc_ctrl
   import spi_regacc_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 2,
   parameter int unsigned WR_BIT     = 2,
   parameter int unsigned IDX_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             byte_done,
   input  byte_t            rx_byte,
   input  byte_t            rd_data,
   output byte_t            next_tx,
   output logic             wr_en,
   output byte_t            wr_data,
   output logic [IDX_W-1:0] idx
);
   localparam int unsigned AW    = BYTE_W * ADDR_BYTES;
   localparam int unsigned HDR   = ADDR_BYTES + 1;
   localparam int unsigned CNT_W = $clog2(HDR + 1);
   localparam logic [CNT_W-1:0] HDR_C  = CNT_W'(HDR);
   localparam logic [CNT_W-1:0] CTRL_C = CNT_W'(ADDR_BYTES);

   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("spi_regacc_ctrl: ADDR_BYTES must be at least 1");
   end
   if (WR_BIT >= BYTE_W) begin : g_bad_wrbit
      $error("spi_regacc_ctrl: WR_BIT must lie inside the control byte");
   end
   if (AW < IDX_W) begin : g_bad_idx
      $error("spi_regacc_ctrl: address narrower than register index");
   end

   logic [CNT_W-1:0] byte_idx;
   logic [AW-1:0]    addr_q;
   byte_t            ctrl_q;
   logic [AW-1:0]    addr_shifted;

   // Address bytes arrive high first; a single-byte address needs no shift.
   if (ADDR_BYTES == 1) begin : g_addr_one
      assign addr_shifted = rx_byte;
   end else begin : g_addr_multi
      assign addr_shifted = {addr_q[AW-BYTE_W-1:0], rx_byte};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_idx <= '0;
         addr_q   <= '0;
         ctrl_q   <= '0;
      end else if (!sel) begin
         byte_idx <= '0;
      end else if (byte_done) begin
         if (byte_idx < CTRL_C) addr_q <= addr_shifted;
         if (byte_idx == CTRL_C) ctrl_q <= rx_byte;
         if (byte_idx == HDR_C) addr_q <= addr_q + AW'(1);
         if (byte_idx < HDR_C) byte_idx <= byte_idx + 1'b1;
      end
   end

   always_comb begin
      if (byte_idx < HDR_C)    next_tx = sig_byte(32'(byte_idx));
      else if (ctrl_q[WR_BIT]) next_tx = '0;
      else                     next_tx = rd_data;
   end

   assign wr_en   = sel && byte_done && (byte_idx == HDR_C) && ctrl_q[WR_BIT];
   assign wr_data = rx_byte;
   assign idx     = addr_q[IDX_W-1:0];

   p_hdr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && byte_done && byte_idx < HDR_C) |=> (byte_idx == $past(byte_idx) + 1'b1));
   p_addr_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && byte_done && byte_idx == HDR_C) |=> (addr_q == $past(addr_q) + AW'(1)));
endmodule

// File: rtl/spi_regacc_regfile.sv
module spi_regacc_regfile
   import spi_regacc_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  byte_t            wr_data,
   output byte_t            rd_data
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_regacc_regfile: DEPTH must be a power of two of at least 2");
   end

   byte_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[idx] <= wr_data;
      end
   end

   assign rd_data = mem[idx];

   logic any_set;
   always_comb begin
      any_set = 1'b0;
      for (int i = 0; i < int'(DEPTH); i++) any_set = any_set | (|mem[i]);
   end

   p_rst_clear_r10: assert property (@(posedge clk) !rst_n |=> !any_set);
endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
   import spi_regacc_pkg::*;
#(
   parameter int unsigned ADDR_BYTES  = 2,
   parameter int unsigned REG_DEPTH   = 16,
   parameter int unsigned WR_BIT      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic mosi,
   output logic miso
);
   localparam int unsigned IDX_W = $clog2(REG_DEPTH);

   logic [2:0]       pins_s;
   logic             sel;
   logic             byte_done;
   byte_t            rx_byte;
   byte_t            next_tx;
   byte_t            rd_data;
   byte_t            wr_data;
   logic             wr_en;
   logic [IDX_W-1:0] idx;

   spi_regacc_sync #(
      .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, mosi}), .q(pins_s)
   );

   spi_regacc_shifter u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(pins_s[2]), .csn_s(pins_s[1]), .mosi_s(pins_s[0]),
      .next_tx(next_tx), .sel(sel), .byte_done(byte_done),
      .rx_byte(rx_byte), .miso(miso)
   );

   spi_regacc_ctrl #(
      .ADDR_BYTES(ADDR_BYTES), .WR_BIT(WR_BIT), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .sel(sel), .byte_done(byte_done),
      .rx_byte(rx_byte), .rd_data(rd_data), .next_tx(next_tx),
      .wr_en(wr_en), .wr_data(wr_data), .idx(idx)
   );

   spi_regacc_regfile #(
      .DEPTH(REG_DEPTH), .IDX_W(IDX_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx),
      .wr_data(wr_data), .rd_data(rd_data)
   );
endmodule

// File: tb/spi_regacc_tb.sv
module spi_regacc_tb;
   import spi_regacc_pkg::*;

   localparam int DEPTH = 16;
   localparam int HALF  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic miso;

   always #10 clk = ~clk;

   spi_regacc u_dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   byte_t exp_mem [DEPTH];
   byte_t tx_buf [32];
   byte_t rx_buf [32];

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input byte_t tx, input int nbits, output byte_t rx);
      rx = '0;
      for (int i = 7; i >= 8 - nbits; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic end_frame();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic run_frame(input int n);
      cs_n = 1'b0;
      for (int k = 0; k < n; k++) send_byte(tx_buf[k], 8, rx_buf[k]);
      end_frame();
   endtask

   task automatic check_hdr(input string ctx);
      for (int k = 0; k < 3; k++)
         chk($sformatf("R2 R3 header byte %0d (%s)", k, ctx), rx_buf[k], 8'(k + 1));
   endtask

   function automatic logic [15:0] addr_of(input int a);
      return {8'(a * 3 + 1), 8'(a + 16 * (a % 3))};
   endfunction

   task automatic write_burst(input logic [15:0] addr, input byte_t ctl, input int n, input string ctx);
      tx_buf[0] = addr[15:8];
      tx_buf[1] = addr[7:0];
      tx_buf[2] = ctl;
      run_frame(3 + n);
      check_hdr(ctx);
      for (int k = 0; k < n; k++) begin
         chk($sformatf("R6 write-phase miso byte %0d (%s)", k, ctx), rx_buf[3 + k], 8'h00);
         exp_mem[(int'(addr) + k) % DEPTH] = tx_buf[3 + k];
      end
   endtask

   task automatic read_burst(input logic [15:0] addr, input byte_t ctl, input int n, input string ctx);
      tx_buf[0] = addr[15:8];
      tx_buf[1] = addr[7:0];
      tx_buf[2] = ctl;
      for (int k = 0; k < n; k++) tx_buf[3 + k] = 8'h5A + 8'(k);
      run_frame(3 + n);
      check_hdr(ctx);
      for (int k = 0; k < n; k++)
         chk($sformatf("R5 read data byte %0d at index %0d (%s)", k, (int'(addr) + k) % DEPTH, ctx),
             rx_buf[3 + k], exp_mem[(int'(addr) + k) % DEPTH]);
   endtask

   initial begin
      byte_t dummy;
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
      repeat (5) @(negedge clk);
      chk("R10 R9 miso low in reset", {7'd0, miso}, 8'h00);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 miso low while deselected", {7'd0, miso}, 8'h00);

      // R10: every register reads zero after reset
      for (int a = 0; a < DEPTH; a++) read_burst(addr_of(a), 8'h00, 1, "R10 initial read");

      // R1 R4 R5 R6: single writes through aliased addresses, mixed control bits
      for (int a = 0; a < DEPTH; a++) begin
         tx_buf[3] = 8'(a * 37 + 5);
         write_burst(addr_of(a), (a % 2 == 1) ? 8'hF4 : 8'h04, 1, "R1 R4 single write");
      end
      for (int a = 0; a < DEPTH; a++)
         read_burst(addr_of((a * 7) % DEPTH), (a % 2 == 1) ? 8'hFB : 8'h00, 1, "R1 R4 single read");

      // R4: MOSI data in a read frame does not write; read twice
      read_burst(16'h0003, 8'h00, 4, "R4 read frame mosi ignored");
      read_burst(16'h0003, 8'h00, 4, "R4 second read unchanged");

      // R7: burst write wrapping past the last register, then burst read
      for (int k = 0; k < 6; k++) tx_buf[3 + k] = 8'hA0 + 8'(k);
      write_burst(16'h00FD, 8'h04, 6, "R7 burst write wrap");
      read_burst(16'h30FC, 8'h00, 8, "R7 burst read wrap");

      // R8: partial data byte is not committed
      cs_n = 1'b0;
      send_byte(8'h00, 8, rx_buf[0]);
      send_byte(8'h05, 8, rx_buf[1]);
      send_byte(8'h04, 8, rx_buf[2]);
      check_hdr("R8 aborted write");
      send_byte(8'hFF, 5, dummy);
      end_frame();
      chk("R9 miso low after abort", {7'd0, miso}, 8'h00);
      read_burst(16'h0005, 8'h00, 1, "R8 partial byte dropped");

      // R8: abort inside header, next frame restarts at signature
      cs_n = 1'b0;
      send_byte(8'h00, 8, dummy);
      send_byte(8'h12, 4, dummy);
      end_frame();
      read_burst(16'h0007, 8'h00, 2, "R8 restart after header abort");

      // R10: synchronous reset clears the register file
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
      read_burst(16'h0000, 8'h00, DEPTH, "R10 reset clears registers");

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule